// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog that software reaches through a small register port. A control word sets a 16-bit reload count, an optional divide-by-N clock prescaler, a run enable, and the choice of alarm on expiry. Once the block is running, a down-counter steps toward zero. Software keeps it alive by writing two fixed 16-bit key values to a service register, one after the other. If the counter runs out first, the block sends a one-cycle pulse on either a reset-request output or a non-maskable-interrupt-request output. It then reloads and starts the next period.

The run enable cannot be cleared once it is set, so software that reads the control word after a write can tell that a stop was refused. A freeze input, gated by a freeze bit in the control word, halts counting, for example while a debugger holds the processor. Two bus-monitor fields are kept in the control word only so that they read back.

The register map uses word index 0 for control, 1 for the current count (read-only) and 2 for the service register. Reads are combinational from the address.

Top module: `wdog_svc_timer`

## Requirements
- R1: A write to control (address 0) stores bits 31:16 (reload count), 15:8 (bus-monitor timing), 7 (bus-monitor enable), 3 (freeze enable), 1 (action select) and 0 (prescale enable). A read of address 0 returns them, and bits 6:4 read as 0.
- R2: Control bit 2 (run enable) can be set by a write but not cleared. A write with bit 2 at 0 leaves it reading 1 until reset.
- R3: Writing 16'h556C and then 16'hAA39 as consecutive writes to the service register (address 2, data bits 15:0) reloads the counter on the clock edge of the second write.
- R4: Any other value after 16'h556C, or any value other than 16'h556C from the idle state, returns the key sequencer to idle without a reload. In particular, 556C, 556C, AA39 gives no reload.
- R5: While the block runs, the count steps down once per tick. On the tick that would take it from 1 to 0, the selected request pulses high for exactly one cycle and the count reloads in that same edge. With the prescaler off, the period is the reload count in clocks.
- R6: When action select is 1, expiry pulses `rst_req`. When it is 0, expiry pulses `nmi_req`. The two outputs are never high together.
- R7: When prescale enable is 1, a tick occurs once every PRESCALE_DIV clocks, counted from the last key reload.
- R8: While `freeze_in` is 1 and the freeze enable bit is 1, the count and the prescaler hold. When freeze enable is 0, `freeze_in` has no effect.
- R9: Address 1 reads the current count in bits 16:0. A write to address 1 changes nothing, and address 2 reads as 0.
- R10: A reload count of 0 loads 65536 (17'h10000).
- R11: After the asynchronous reset, control reads 0, the count reads 65536 and both requests are low. While stopped, the count follows the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word index (0 control, 1 count, 2 service) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| freeze_in | input | 1 | External halt request |
| rst_req | output | 1 | One-cycle reset request on expiry |
| nmi_req | output | 1 | One-cycle interrupt request on expiry |

## Verification
A control write takes effect on the edge that accepts it, and so does the second key write: the reloaded count is visible at the next falling edge. Each later tick removes one count per edge, or one per PRESCALE_DIV edges with the prescaler on. The expiry pulse shows up on the same edge as the reload that follows from 1. The bench drives every write at a falling edge, advances exactly one edge per write, and samples at the falling edges. It can therefore predict the count from the number of edges since the last reload and compare it exactly. For the key table, each entry starts from a reload and four idle edges, so the result is either the reload count itself or that count minus six.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [15:0] KEY_FIRST  = 16'h556C;
  localparam logic [15:0] KEY_SECOND = 16'hAA39;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_SVC  = 2'd2;

  localparam int CTL_PRE = 0;
  localparam int CTL_ACT = 1;
  localparam int CTL_RUN = 2;
  localparam int CTL_FRZ = 3;

  localparam logic [31:0] CTRL_KEEP_MASK = 32'hFFFF_FF8B;

  localparam int CNT_W = 17;

  typedef enum logic {KS_IDLE, KS_ARMED} key_state_e;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  output logic [31:0] ctrl_q
);
  logic [31:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = wdata & CTRL_KEEP_MASK;
      ctrl_d[CTL_RUN] = wdata[CTL_RUN] | ctrl_q[CTL_RUN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_svc,
  input  logic [15:0] svc_data,
  output logic        svc_fire
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    svc_fire = 1'b0;
    if (wr_svc) begin
      unique case (st_q)
        KS_IDLE:  st_d = (svc_data == KEY_FIRST) ? KS_ARMED : KS_IDLE;
        KS_ARMED: begin
          st_d     = KS_IDLE;
          svc_fire = (svc_data == KEY_SECOND);
        end
        default:  st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int PRESCALE_DIV = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic halt,
  input  logic restart,
  input  logic pre_en,
  output logic tick
);
  localparam int PW = (PRESCALE_DIV > 2) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE_DIV - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          step_en;
  logic          at_last;

  assign step_en = run & ~halt;
  assign at_last = (pcnt_q == PLAST);
  assign tick    = step_en & (~pre_en | at_last);

  always_comb begin
    pcnt_d = pcnt_q;
    if (restart || !run)      pcnt_d = '0;
    else if (step_en && pre_en) pcnt_d = at_last ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             svc_fire,
  input  logic             act_sel,
  input  logic [15:0]      timeout,
  output logic [CNT_W-1:0] cnt_q,
  output logic             rst_req,
  output logic             nmi_req
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] reload_val;
  logic             expire;
  logic             rst_d, nmi_d;

  assign reload_val = (timeout == 16'd0) ? {1'b1, 16'd0} : {1'b0, timeout};
  assign expire     = run & tick & ~svc_fire & (cnt_q <= CNT_W'(1));
  assign rst_d      = expire & act_sel;
  assign nmi_d      = expire & ~act_sel;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || svc_fire || expire) cnt_d = reload_val;
    else if (tick)                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= {1'b1, 16'd0};
      rst_req <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rst_req <= rst_d;
      nmi_req <= nmi_d;
    end
  end
endmodule

// File: rtl/wdog_svc_timer.sv
module wdog_svc_timer
  import wdog_pkg::*;
#(
  parameter int PRESCALE_DIV = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        freeze_in,
  output logic        rst_req,
  output logic        nmi_req
);
  logic [31:0]      ctrl_q;
  logic             wr_ctrl, wr_svc;
  logic             svc_fire;
  logic             tick;
  logic             halt;
  logic [CNT_W-1:0] cnt_q;

  assign wr_ctrl = wr_en & (addr == ADDR_CTRL);
  assign wr_svc  = wr_en & (addr == ADDR_SVC);
  assign halt    = freeze_in & ctrl_q[CTL_FRZ];

  wdog_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata), .ctrl_q(ctrl_q)
  );

  wdog_key_seq u_key (
    .clk(clk), .rst_n(rst_n), .wr_svc(wr_svc), .svc_data(wdata[15:0]),
    .svc_fire(svc_fire)
  );

  wdog_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTL_RUN]), .halt(halt),
    .restart(svc_fire), .pre_en(ctrl_q[CTL_PRE]), .tick(tick)
  );

  wdog_down_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[CTL_RUN]), .tick(tick),
    .svc_fire(svc_fire), .act_sel(ctrl_q[CTL_ACT]), .timeout(ctrl_q[31:16]),
    .cnt_q(cnt_q), .rst_req(rst_req), .nmi_req(nmi_req)
  );

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdata = ctrl_q;
      ADDR_CNT:  rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_svc_timer_chk.sv
module wdog_svc_timer_chk
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             act_q,
  input logic             frz_q,
  input logic             freeze_in,
  input logic             svc_fire,
  input logic [CNT_W-1:0] cnt_q,
  input logic             rst_req,
  input logic             nmi_req
);
  assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && nmi_req));

  assert_rst_follows_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(act_q));

  assert_nmi_follows_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> !$past(act_q));

  assert_freeze_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && frz_q && freeze_in && !svc_fire) |=> $stable(cnt_q));

  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);

  assert_req_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || nmi_req) |-> $past(run_q));
endmodule

bind wdog_svc_timer wdog_svc_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(ctrl_q[2]), .act_q(ctrl_q[1]),
  .frz_q(ctrl_q[3]), .freeze_in(freeze_in), .svc_fire(svc_fire),
  .cnt_q(cnt_q), .rst_req(rst_req), .nmi_req(nmi_req)
);

// File: tb/wdog_svc_timer_bench.sv
module wdog_svc_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        freeze_in = 1'b0;
  logic        rst_req, nmi_req;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic finished = 1'b0;

  wdog_svc_timer #(.PRESCALE_DIV(DIV)) u_wdog_svc_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .freeze_in(freeze_in), .rst_req(rst_req), .nmi_req(nmi_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // key table entry: {first write, second write, reload expected}
  localparam logic [32:0] KEY_VEC [7] = '{
    {16'h556C, 16'hAA39, 1'b1},
    {16'hAA39, 16'h556C, 1'b0},
    {16'h556C, 16'h556C, 1'b0},
    {16'h1234, 16'hAA39, 1'b0},
    {16'h556C, 16'hAA38, 1'b0},
    {16'h0000, 16'h0000, 1'b0},
    {16'h556C, 16'hAA39, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic service();
    wr(2'd2, 32'h556C);
    wr(2'd2, 32'hAA39);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(input logic [15:0] tout, input logic [7:0] low);
    return {tout, 8'h00, low};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !finished) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    rd(2'd0, v); chk("R11 ctrl", v, 32'h0);
    rd(2'd1, v); chk("R11 count", v, 32'h1_0000);
    chk("R11 rst_req", {31'b0, rst_req}, 32'h0);
    chk("R11 nmi_req", {31'b0, nmi_req}, 32'h0);

    // R1 readback with all bits, run left off
    wr(2'd0, 32'hFFFF_FFFB);
    rd(2'd0, v); chk("R1 stored fields", v, 32'hFFFF_FF8B);
    rd(2'd2, v); chk("R9 service reads zero", v, 32'h0);
    // R11 count tracks reload while stopped
    wr(2'd0, ctl(16'd1000, 8'h00));
    idle(1);
    rd(2'd1, v); chk("R11 stopped count follows", v, 32'd1000);
    // start: reset action, bus monitor fields
    wr(2'd0, {16'd1000, 8'hA5, 8'h86});
    rd(2'd0, v); chk("R1 readback run", v, {16'd1000, 8'hA5, 8'h86});
    // R2 stop refused
    wr(2'd0, {16'd1000, 8'hA5, 8'h82});
    rd(2'd0, v); chk("R2 run sticky", v, {16'd1000, 8'hA5, 8'h86});

    // R3/R4 key table
    foreach (KEY_VEC[i]) begin
      wr(2'd2, 32'h0);
      service();
      idle(4);
      wr(2'd2, {16'h0, KEY_VEC[i][32:17]});
      wr(2'd2, {16'h0, KEY_VEC[i][16:1]});
      rd(2'd1, v);
      if (KEY_VEC[i][0]) chk("R3 key pair reloads", v, 32'd1000);
      else               chk("R4 bad key no reload", v, 32'd994);
    end
    // R4 556C,556C,AA39 gives no reload
    wr(2'd2, 32'h0); service(); idle(4);
    wr(2'd2, 32'h556C); wr(2'd2, 32'h556C); wr(2'd2, 32'hAA39);
    rd(2'd1, v); chk("R4 repeated first key", v, 32'd993);

    // R5/R6 expiry with reset action, period 5
    wr(2'd0, ctl(16'd5, 8'h06));
    service();
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      rd(2'd1, v);
      if (k == 5) begin
        chk("R5 pulse and reload count", v, 32'd5);
        chk("R6 rst_req on expiry", {31'b0, rst_req}, 32'd1);
        chk("R6 nmi_req quiet", {31'b0, nmi_req}, 32'd0);
      end else begin
        chk("R5 countdown", v, (k < 5) ? 32'(5 - k) : 32'd4);
        chk("R5 no pulse", {31'b0, rst_req}, 32'd0);
      end
    end
    // R6 interrupt action
    wr(2'd0, ctl(16'd5, 8'h04));
    service();
    idle(4);
    chk("R6 nmi not yet", {31'b0, nmi_req}, 32'd0);
    idle(1);
    chk("R6 nmi_req on expiry", {31'b0, nmi_req}, 32'd1);
    chk("R6 rst_req quiet", {31'b0, rst_req}, 32'd0);
    idle(1);
    chk("R5 one-cycle pulse", {31'b0, nmi_req}, 32'd0);

    // R8 freeze
    wr(2'd0, ctl(16'd5, 8'h0E));
    freeze_in = 1'b1;
    service();
    idle(10);
    rd(2'd1, v); chk("R8 frozen count", v, 32'd5);
    chk("R8 no expiry frozen", {31'b0, rst_req}, 32'd0);
    wr(2'd1, 32'h0000_0002);
    rd(2'd1, v); chk("R9 count write ignored", v, 32'd5);
    freeze_in = 1'b0;
    idle(2);
    rd(2'd1, v); chk("R8 resumes", v, 32'd3);
    freeze_in = 1'b1;
    wr(2'd0, ctl(16'd5, 8'h06));
    service();
    idle(2);
    rd(2'd1, v); chk("R8 freeze bit clear", v, 32'd3);
    freeze_in = 1'b0;

    // R10 zero timeout
    wr(2'd0, ctl(16'd0, 8'h06));
    service();
    rd(2'd1, v); chk("R10 zero is 65536", v, 32'h1_0000);
    idle(1);
    rd(2'd1, v); chk("R10 then counts", v, 32'h0_FFFF);

    // R7 prescaler
    wr(2'd0, ctl(16'd3, 8'h07));
    service();
    idle(3);
    rd(2'd1, v); chk("R7 held before divide", v, 32'd3);
    idle(1);
    rd(2'd1, v); chk("R7 first tick", v, 32'd2);
    idle(7);
    rd(2'd1, v); chk("R7 second tick", v, 32'd1);
    chk("R7 no early pulse", {31'b0, rst_req}, 32'd0);
    idle(1);
    chk("R7 expiry after 3 ticks", {31'b0, rst_req}, 32'd1);
    rd(2'd1, v); chk("R7 reload", v, 32'd3);

    // R11 / R2 reset clears run
    rst_n = 1'b0;
    #1;
    rd(2'd0, v); chk("R2 reset clears run", v, 32'h0);
    chk("R11 outputs low in reset", {30'b0, rst_req, nmi_req}, 32'h0);
    idle(1);
    rst_n = 1'b1;
    idle(1);
    rd(2'd1, v); chk("R11 count after reset", v, 32'h1_0000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule